// File: doc/BRIEF.md
# Dual-Space Data Access Checker

This block stands between the address generators of a DSP-capable processor and a 16-bit wide data RAM. The byte-addressed space holds an implemented region from address zero up to a configurable top. Inside it a configurable boundary separates the lower X region, which includes the special-register area below 0x0800, from the upper Y region. Every address at or above the top is unimplemented.

Each access arrives with its effective address, a read or write strobe, a byte/word flag, a flag marking a DSP-class instruction and the number of the pointer register that produced the address. Writes always see X and Y as one linear space. For DSP-class reads, the dedicated X pointers may only reach X and the dedicated Y pointers may only reach Y. Any other read comes back as zero. The block places bytes on the correct lanes, blocks faulting writes, and reports every unimplemented or misaligned access with a registered trap pulse.

Top module: `dsa_guard`

## Requirements
- R1: An address below `RAM_TOP` is implemented. The Y region is `Y_BASE` up to `RAM_TOP - 1`. Every other implemented address, including 0x0000–0x07FF, is X.
- R2: A DSP-class read through pointer 8 or 9 that hits the Y region returns 0x0000 on `rd_data` and leaves `ram_rd` low.
- R3: A DSP-class read through pointer 10 or 11 that hits the X region returns 0x0000 on `rd_data` and leaves `ram_rd` low.
- R4: Reads that are not DSP-class, and DSP-class reads through any pointer other than 8–11, reach X and Y alike.
- R5: An access at or above `RAM_TOP` reads as 0x0000, drives `ram_we` to 2'b00 and raises a trap.
- R6: Writes ignore the DSP flag and the pointer number. Any implemented address can be written, including by pointer 13 or pointer 8 into Y.
- R7: A word access uses `ram_addr` = address bits [15:1], and an aligned word write drives `ram_we` = 2'b11. Data is little-endian: the even byte is bits [7:0].
- R8: A byte read returns the addressed byte in bits [7:0], the even address giving the low lane and the odd address the high lane. Bits [15:8] are zero.
- R9: A byte write drives `ram_we` = 2'b01 for an even address and 2'b10 for an odd one, with the byte repeated on both halves of `ram_wdata`. The other byte of the word is unchanged.
- R10: A word read at an odd address completes and returns the whole word at address bits [15:1], and it raises a trap.
- R11: A word write at an odd address drives `ram_we` = 2'b00, so memory is unchanged, and it raises a trap.
- R12: `trap` is registered. It is high for exactly the one cycle after each clock edge that samples a faulting access, and it is low after reset and after non-faulting or idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_addr | input | 16 | Effective byte address |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_byte | input | 1 | 1 = byte access, 0 = word access |
| acc_dsp | input | 1 | DSP-class instruction |
| acc_ptr | input | 4 | Pointer register number |
| acc_wdata | input | 16 | Write data (byte in bits [7:0]) |
| ram_addr | output | 15 | RAM word address |
| ram_rd | output | 1 | RAM read enable |
| ram_we | output | 2 | Per-byte RAM write enables |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data (combinational) |
| rd_data | output | 16 | Aligned, filtered read data |
| trap | output | 1 | Address-error trap pulse |

## Verification
Reads of the same stored words are issued through each DSP pointer class and through general pointers. This separates blanking that depends on the pointer from blanking that depends on the address, and it probes the words on both sides of the X/Y boundary and at the top of RAM. Byte writes to both lanes, followed by a word readback, separate lane selection from whole-word writes. Misaligned word writes, followed by an aligned readback, show that memory was left untouched. A pseudo-random mix of aligned accesses, compared every cycle against a behavioural memory, exposes address-slicing and lane errors that the fixed cases miss.

// File: rtl/dsa_guard.sv
module dsa_guard #(
  parameter logic [15:0] Y_BASE  = 16'h1800,
  parameter logic [15:0] RAM_TOP = 16'h2800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] acc_addr,
  input  logic        acc_rd,
  input  logic        acc_wr,
  input  logic        acc_byte,
  input  logic        acc_dsp,
  input  logic [3:0]  acc_ptr,
  input  logic [15:0] acc_wdata,
  output logic [14:0] ram_addr,
  output logic        ram_rd,
  output logic [1:0]  ram_we,
  output logic [15:0] ram_wdata,
  input  logic [15:0] ram_rdata,
  output logic [15:0] rd_data,
  output logic        trap
);
  logic impl, in_y, x_only, y_only, blank, odd_word, fault;

  assign impl     = acc_addr < RAM_TOP;
  assign in_y     = impl && (acc_addr >= Y_BASE);
  assign x_only   = acc_dsp && (acc_ptr == 4'd8  || acc_ptr == 4'd9);
  assign y_only   = acc_dsp && (acc_ptr == 4'd10 || acc_ptr == 4'd11);
  assign blank    = !impl || (x_only && in_y) || (y_only && !in_y);
  assign odd_word = !acc_byte && acc_addr[0];
  assign fault    = (acc_rd || acc_wr) && (!impl || odd_word);

  assign ram_addr  = acc_addr[15:1];
  assign ram_rd    = acc_rd && !blank;
  assign ram_wdata = acc_byte ? {2{acc_wdata[7:0]}} : acc_wdata;

  always_comb begin
    ram_we = 2'b00;
    if (acc_wr && impl && !odd_word)
      ram_we = !acc_byte ? 2'b11 : (acc_addr[0] ? 2'b10 : 2'b01);
  end

  always_comb begin
    if (!acc_rd || blank)  rd_data = 16'h0000;
    else if (acc_byte)     rd_data = {8'h00, acc_addr[0] ? ram_rdata[15:8] : ram_rdata[7:0]};
    else                   rd_data = ram_rdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) trap <= 1'b0;
    else        trap <= fault;
endmodule

// File: rtl/dsa_guard_chk.sv
module dsa_guard_chk #(
  parameter logic [15:0] Y_BASE  = 16'h1800,
  parameter logic [15:0] RAM_TOP = 16'h2800
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] acc_addr,
  input logic        acc_rd,
  input logic        acc_wr,
  input logic        acc_byte,
  input logic        acc_dsp,
  input logic [3:0]  acc_ptr,
  input logic [1:0]  ram_we,
  input logic [15:0] rd_data,
  input logic        trap
);
  // R2
  x_ptr_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_dsp && (acc_ptr == 4'd8 || acc_ptr == 4'd9) &&
     acc_addr >= Y_BASE && acc_addr < RAM_TOP) |-> rd_data == 16'h0000);
  // R5
  unimpl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr >= RAM_TOP) |-> (ram_we == 2'b00 && rd_data == 16'h0000));
  // R9
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_byte) |-> $countones(ram_we) <= 1);
  // R11
  odd_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_byte && acc_addr[0]) |-> ram_we == 2'b00);
  // R12
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> $past(acc_rd || acc_wr));
  // R12
  trap_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_addr >= RAM_TOP) |=> trap);
endmodule

bind dsa_guard dsa_guard_chk #(.Y_BASE(Y_BASE), .RAM_TOP(RAM_TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
  .acc_byte(acc_byte), .acc_dsp(acc_dsp), .acc_ptr(acc_ptr), .ram_we(ram_we),
  .rd_data(rd_data), .trap(trap));

// File: tb/sim_dsa_guard.sv
`timescale 1ns/1ps
module sim_dsa_guard;
  localparam logic [15:0] YB = 16'h1800;
  localparam logic [15:0] RT = 16'h2800;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] acc_addr = '0, acc_wdata = '0, ram_rdata = '0, rd_data, ram_wdata;
  logic acc_rd = 0, acc_wr = 0, acc_byte = 0, acc_dsp = 0, ram_rd, trap;
  logic [3:0] acc_ptr = '0;
  logic [14:0] ram_addr;
  logic [1:0] ram_we;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] mem [int];
  logic [15:0] ref_mem [int];

  always #4 clk = ~clk;

  dsa_guard #(.Y_BASE(YB), .RAM_TOP(RT)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_byte(acc_byte), .acc_dsp(acc_dsp), .acc_ptr(acc_ptr), .acc_wdata(acc_wdata),
    .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .rd_data(rd_data), .trap(trap));

  function automatic logic [15:0] peek(input bit use_ref, input int idx);
    if (use_ref) return ref_mem.exists(idx) ? ref_mem[idx] : 16'h0000;
    return mem.exists(idx) ? mem[idx] : 16'h0000;
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit rd, input bit byt, input bit dsp,
                        input logic [3:0] ptr, input logic [15:0] addr,
                        input logic [15:0] wd, input string req);
    bit impl, iny, blank, odd;
    logic [15:0] w, exp_rd;
    logic [1:0] exp_we;
    int idx;
    @(negedge clk);
    impl = addr < RT;
    iny  = impl && addr >= YB;
    odd  = !byt && addr[0];
    idx  = int'(addr[15:1]);
    blank = !impl;
    if (dsp && (ptr == 8 || ptr == 9) && iny) blank = 1;
    if (dsp && (ptr == 10 || ptr == 11) && !iny) blank = 1;
    w = peek(1, idx);
    exp_rd = 16'h0000;
    if (rd && !blank) exp_rd = byt ? {8'h00, addr[0] ? w[15:8] : w[7:0]} : w;
    exp_we = 2'b00;
    if (wr && impl && !odd) exp_we = byt ? (addr[0] ? 2'b10 : 2'b01) : 2'b11;
    acc_wr = wr; acc_rd = rd; acc_byte = byt; acc_dsp = dsp; acc_ptr = ptr;
    acc_addr = addr; acc_wdata = wd;
    ram_rdata = peek(0, idx);
    #2;
    if (rd) check(req, "rd_data", rd_data, exp_rd);
    if (wr) check(req, "ram_we", {14'b0, ram_we}, {14'b0, exp_we});
    @(posedge clk);
    if (ram_we != 2'b00) begin
      w = peek(0, int'(ram_addr));
      if (ram_we[0]) w[7:0]  = ram_wdata[7:0];
      if (ram_we[1]) w[15:8] = ram_wdata[15:8];
      mem[int'(ram_addr)] = w;
    end
    if (exp_we != 2'b00) begin
      w = peek(1, idx);
      if (byt && addr[0]) w[15:8] = wd[7:0];
      else if (byt)      w[7:0]  = wd[7:0];
      else               w = wd;
      ref_mem[idx] = w;
    end
    #1;
    check("R12", "trap", {15'b0, trap}, {15'b0, (wr || rd) && (!impl || odd)});
  endtask

  task automatic idle();
    access(0, 0, 0, 0, 4'd0, 16'h0000, 16'h0000, "R12");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    #1;
    check("R12", "trap in reset", {15'b0, trap}, 16'h0000);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle();
    // R7 word write and readback
    access(1, 0, 0, 0, 4'd1, 16'h0900, 16'hA55A, "R7");
    access(0, 1, 0, 0, 4'd1, 16'h0900, 16'h0000, "R7");
    // R9 byte writes on both lanes, then R7 little-endian word readback
    access(1, 0, 1, 0, 4'd2, 16'h0902, 16'h0011, "R9");
    access(1, 0, 1, 0, 4'd2, 16'h0903, 16'hFF22, "R9");
    access(0, 1, 0, 0, 4'd2, 16'h0902, 16'h0000, "R9");
    // R8 byte reads
    access(0, 1, 1, 0, 4'd3, 16'h0903, 16'h0000, "R8");
    access(0, 1, 1, 0, 4'd3, 16'h0900, 16'h0000, "R8");
    // R6 DSP writes into combined space
    access(1, 0, 0, 1, 4'd8, 16'h1A00, 16'hBEEF, "R6");
    access(1, 0, 0, 1, 4'd13, 16'h0A00, 16'h4321, "R6");
    access(0, 1, 0, 0, 4'd0, 16'h0A00, 16'h0000, "R6");
    // R2 / R3 pointer-restricted reads
    access(0, 1, 0, 1, 4'd8, 16'h1A00, 16'h0000, "R2");
    access(0, 1, 0, 1, 4'd9, 16'h0900, 16'h0000, "R2");
    access(0, 1, 0, 1, 4'd10, 16'h1A00, 16'h0000, "R3");
    access(0, 1, 0, 1, 4'd11, 16'h0900, 16'h0000, "R3");
    // R4 general pointers see both regions
    access(0, 1, 0, 1, 4'd4, 16'h1A00, 16'h0000, "R4");
    access(0, 1, 0, 0, 4'd8, 16'h1A00, 16'h0000, "R4");
    // R1 boundaries
    access(1, 0, 0, 0, 4'd1, YB - 16'd2, 16'h1234, "R1");
    access(0, 1, 0, 1, 4'd10, YB - 16'd2, 16'h0000, "R1");
    access(0, 1, 0, 1, 4'd8, YB - 16'd2, 16'h0000, "R1");
    access(1, 0, 0, 0, 4'd1, YB, 16'h5678, "R1");
    access(0, 1, 0, 1, 4'd11, YB, 16'h0000, "R1");
    access(1, 0, 0, 0, 4'd1, RT - 16'd2, 16'h7777, "R1");
    access(0, 1, 0, 1, 4'd10, RT - 16'd2, 16'h0000, "R1");
    access(1, 0, 0, 0, 4'd1, 16'h0010, 16'h0C0C, "R1");
    access(0, 1, 0, 1, 4'd9, 16'h0010, 16'h0000, "R1");
    // R5 unimplemented
    access(0, 1, 0, 0, 4'd1, RT, 16'h0000, "R5");
    idle();
    access(1, 0, 0, 0, 4'd1, 16'h3000, 16'hDEAD, "R5");
    access(1, 0, 1, 0, 4'd1, 16'hFFFF, 16'h00AB, "R5");
    idle();
    // R11 misaligned word write blocked
    access(1, 0, 0, 0, 4'd1, 16'h0901, 16'hFFFF, "R11");
    access(0, 1, 0, 0, 4'd1, 16'h0900, 16'h0000, "R11");
    // R10 misaligned word read completes
    access(0, 1, 0, 0, 4'd1, 16'h0903, 16'h0000, "R10");
    idle();
    // mixed aligned traffic against the reference memory
    lfsr = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(lfsr[0], !lfsr[0], lfsr[1], lfsr[2], lfsr[6:3],
             {4'h0, lfsr[15:5], lfsr[1] & lfsr[4]} + 16'h0800,
             {lfsr[7:0], lfsr[15:8]}, "R7");
    end
    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule